// File: doc/BRIEF.md
# Paged Host Register Block with Interrupt Tree

This block is the byte-wide host-facing register file of a network controller. The host reaches sixteen byte offsets over a simple synchronous bus. The lower eight offsets mean the same thing on every page. The upper eight are reinterpreted according to a page number that the host stores at offset 0x01. Offset 0x00 is shared between two functions: a write issues a command, and a read returns live MAC status.

MAC events arrive as single-cycle pulses and are latched into a sticky interrupt status register. That register is filtered by a per-bit mask and gated by a global enable and a host mask to form one host interrupt line. A forced-interrupt command feeds the same status register, so software can test the whole path. A software-reset command returns all held state to zero.

The MAC datapath and the data port are not part of this block. The block only receives their event pulses, status levels and the receive byte count, and it hands back one-cycle command strobes.

Top module: `paged_host_regs`

## Requirements
- R1: Offsets 0x00–0x07 decode identically whatever the page. Offset 0x01 is a readable and writable 8-bit page number.
- R2: Offsets 0x08–0x0F depend on the page.
  - Page 1: 0x0C is the read/write interrupt mask and 0x0E is the read/write configuration byte.
  - Page 0: 0x0E returns receive count bits 7:0 and 0x0F returns count bits 12:8 in its bits 4:0.
  - On any other page, upper offsets read 0x00 and writes to them change nothing.
- R3: A read of offset 0x00 returns mac_stat in bits 3:0 and zero above (bit 0 full packet, 1 partial 64 bytes, 2 rejected, 3 transmit pending). A write to 0x00 does not alter that readback.
- R4: The status register at offset 0x06 latches event pulses: mac_evt bit 0 tx overflow, 1 tx done, 2 MAC event, 4 rx early, 5 rx packet, 6 rx reject. Set bits stay set. mac_evt bits 3 and 7 are ignored.
- R5: Writing a 1 to a status bit clears it. An event on the same bit in the same cycle leaves it set.
- R6: A command with bit 3 set sets status bit 7 (forced interrupt).
- R7: Every command write loads the global interrupt enable from its bit 2.
- R8: host_irq equals enable AND NOT host-mask AND OR(status AND mask), registered one cycle after that state.
- R9: Offset 0x07 reads bit 0 = OR(status AND mask), independent of enable and host mask. Bit 1 is the read/write host mask. Other bits read 0.
- R10: When configuration bit 7 is set, bits 7:5 of the page-0 0x0F readback carry mac_stat bits 2:0. When it is clear, those bits read 0.
- R11: A command with bit 1 set clears page, status, mask, configuration, host mask and enable on that clock edge. All other bits of that write are ignored.
- R12: Command bits 0 (transmit), 4 (clear FIFO), 5 (clear overrun) and 6 (restart transmit) appear on cmd_strobe at the same positions for exactly one cycle after the write. All other strobe bits stay 0.
- R13: bus_rdata is registered. It is valid the cycle after bus_rd and holds otherwise. Unimplemented offsets read 0x00, and reads never change state.

Top module port order follows the table below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| mac_evt | input | 8 | Event pulses, positions as in R4 |
| mac_stat | input | 4 | Status levels, positions as in R3 |
| rx_cnt | input | 13 | Receive byte count |
| cmd_strobe | output | 8 | One-cycle command pulses to the MAC |
| host_irq | output | 1 | Host interrupt line |

## Verification
The interrupt tree is exercised with several source patterns:
- An unmasked event, which raises the line.
- A masked event, which sets status but leaves both the pending bit and the line low.
- An all-ones event vector, which exposes the two ignored positions.
- A forced interrupt, which travels the command-to-status path.

A clear and an event are applied to the same status bit in one cycle, alongside a clear on a second bit, which separates correct clear-then-set ordering from a stuck or lost clear.

The page decode is tried with the same upper offset on pages 0, 1, 2 and 7, which distinguishes a decode that ignores the page from one that aliases pages. The count readback is taken with the configuration bit both clear and set.

// File: rtl/phr_pkg.sv
package phr_pkg;
  localparam int unsigned REG_W = 8;

  localparam logic [3:0] OFS_CMD    = 4'h0;
  localparam logic [3:0] OFS_PAGE   = 4'h1;
  localparam logic [3:0] OFS_ISR    = 4'h6;
  localparam logic [3:0] OFS_GIR    = 4'h7;
  localparam logic [3:0] OFS_MASK   = 4'hC;
  localparam logic [3:0] OFS_CFG    = 4'hE;
  localparam logic [3:0] OFS_CNT_LO = 4'hE;
  localparam logic [3:0] OFS_CNT_HI = 4'hF;

  localparam logic [REG_W-1:0] PG_DATA = 8'd0;
  localparam logic [REG_W-1:0] PG_INTR = 8'd1;

  localparam int unsigned CB_SRST  = 1;
  localparam int unsigned CB_IEN   = 2;
  localparam int unsigned CB_FORCE = 3;
  localparam int unsigned GB_HMASK = 1;
  localparam int unsigned CFG_MIRROR = 7;

  // command bits forwarded to the MAC as strobes
  localparam logic [REG_W-1:0] STROBE_BITS = 8'h71;
  // status bits fed by MAC events
  localparam logic [REG_W-1:0] EVT_BITS    = 8'h77;
  // status bits that hold state (events plus forced bit)
  localparam logic [REG_W-1:0] LIVE_BITS   = 8'hF7;

  typedef struct packed {
    logic cmd;
    logic page;
    logic isr;
    logic gir;
    logic mask;
    logic cfg;
  } wr_sel_t;
endpackage

// File: rtl/phr_cmd.sv
module phr_cmd
  import phr_pkg::*;
#(
  parameter int unsigned DW = REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr,
  input  logic [DW-1:0] wdata,
  output logic          sreset,
  output logic          force_set,
  output logic          irq_en,
  output logic [DW-1:0] cmd_strobe
);
  assign sreset    = cmd_wr && wdata[CB_SRST];
  assign force_set = cmd_wr && wdata[CB_FORCE] && !wdata[CB_SRST];

  always_ff @(posedge clk) begin
    if (rst || sreset) irq_en <= 1'b0;
    else if (cmd_wr)   irq_en <= wdata[CB_IEN];
  end

  always_ff @(posedge clk) begin
    if (rst)                               cmd_strobe <= '0;
    else if (cmd_wr && !wdata[CB_SRST])    cmd_strobe <= wdata & STROBE_BITS;
    else                                   cmd_strobe <= '0;
  end

  // R12
  strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_strobe != '0) |-> $past(cmd_wr && !wdata[CB_SRST]));
endmodule

// File: rtl/phr_irq.sv
module phr_irq
  import phr_pkg::*;
#(
  parameter int unsigned DW = REG_W
) (
  input  logic          clk,
  input  logic          clr,
  input  logic [DW-1:0] mac_evt,
  input  logic          force_set,
  input  logic          isr_wr,
  input  logic          mask_wr,
  input  logic          gir_wr,
  input  logic [DW-1:0] wdata,
  input  logic          irq_en,
  output logic [DW-1:0] isr,
  output logic [DW-1:0] imr,
  output logic          hmask,
  output logic          pending,
  output logic          host_irq
);
  logic [DW-1:0] set_vec;
  logic [DW-1:0] clr_vec;

  assign set_vec = (mac_evt & EVT_BITS) | {force_set, {(DW-1){1'b0}}};
  assign clr_vec = isr_wr ? wdata : '0;

  for (genvar b = 0; b < DW; b++) begin : g_isr
    if (LIVE_BITS[b]) begin : g_live
      logic bit_q;
      always_ff @(posedge clk) begin
        if (clr) bit_q <= 1'b0;
        else     bit_q <= set_vec[b] | (bit_q & ~clr_vec[b]);
      end
      assign isr[b] = bit_q;
    end else begin : g_tied
      assign isr[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (clr)          imr <= '0;
    else if (mask_wr) imr <= wdata;
  end

  always_ff @(posedge clk) begin
    if (clr)         hmask <= 1'b0;
    else if (gir_wr) hmask <= wdata[GB_HMASK];
  end

  assign pending = |(isr & imr);

  always_ff @(posedge clk) begin
    if (clr) host_irq <= 1'b0;
    else     host_irq <= irq_en && !hmask && pending;
  end

  // R5
  evt_wins_chk: assert property (@(posedge clk) disable iff (clr)
    (set_vec != '0) |=> ((isr & $past(set_vec)) == $past(set_vec)));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (clr)
    host_irq |-> $past(irq_en && !hmask && pending));
endmodule

// File: rtl/phr_page_cfg.sv
module phr_page_cfg
  import phr_pkg::*;
#(
  parameter int unsigned DW = REG_W
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          page_wr,
  input  logic          cfg_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] page_q,
  output logic [DW-1:0] cfg_q
);
  always_ff @(posedge clk) begin
    if (clr)          page_q <= '0;
    else if (page_wr) page_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (clr)         cfg_q <= '0;
    else if (cfg_wr) cfg_q <= wdata;
  end
endmodule

// File: rtl/paged_host_regs.sv
module paged_host_regs
  import phr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DW     = REG_W,
  parameter int unsigned STAT_W = 4,
  parameter int unsigned CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     mac_evt,
  input  logic [STAT_W-1:0] mac_stat,
  input  logic [CNT_W-1:0]  rx_cnt,
  output logic [DW-1:0]     cmd_strobe,
  output logic              host_irq
);
  localparam int unsigned HI_CNT = CNT_W - DW;
  localparam int unsigned FLAG_W = DW - HI_CNT;

  wr_sel_t        sel;
  logic           sreset, force_set, irq_en, clr;
  logic           hmask, pending;
  logic [DW-1:0]  isr, imr, page_q, cfg_q;
  logic [DW-1:0]  rd_val;
  logic [FLAG_W-1:0] mirror;

  always_comb begin
    sel      = '0;
    sel.cmd  = bus_wr && (bus_addr == ADDR_W'(OFS_CMD));
    sel.page = bus_wr && (bus_addr == ADDR_W'(OFS_PAGE));
    sel.isr  = bus_wr && (bus_addr == ADDR_W'(OFS_ISR));
    sel.gir  = bus_wr && (bus_addr == ADDR_W'(OFS_GIR));
    sel.mask = bus_wr && (bus_addr == ADDR_W'(OFS_MASK)) && (page_q == PG_INTR);
    sel.cfg  = bus_wr && (bus_addr == ADDR_W'(OFS_CFG))  && (page_q == PG_INTR);
  end

  assign clr = rst || sreset;

  phr_cmd #(.DW(DW)) u_cmd (
    .clk(clk), .rst(rst), .cmd_wr(sel.cmd), .wdata(bus_wdata),
    .sreset(sreset), .force_set(force_set), .irq_en(irq_en),
    .cmd_strobe(cmd_strobe)
  );

  phr_irq #(.DW(DW)) u_irq (
    .clk(clk), .clr(clr), .mac_evt(mac_evt), .force_set(force_set),
    .isr_wr(sel.isr), .mask_wr(sel.mask), .gir_wr(sel.gir),
    .wdata(bus_wdata), .irq_en(irq_en), .isr(isr), .imr(imr),
    .hmask(hmask), .pending(pending), .host_irq(host_irq)
  );

  phr_page_cfg #(.DW(DW)) u_pg (
    .clk(clk), .clr(clr), .page_wr(sel.page), .cfg_wr(sel.cfg),
    .wdata(bus_wdata), .page_q(page_q), .cfg_q(cfg_q)
  );

  assign mirror = cfg_q[CFG_MIRROR] ? FLAG_W'(mac_stat) : '0;

  always_comb begin
    rd_val = '0;
    if (!bus_addr[ADDR_W-1]) begin
      unique case (bus_addr)
        ADDR_W'(OFS_CMD):  rd_val = DW'(mac_stat);
        ADDR_W'(OFS_PAGE): rd_val = page_q;
        ADDR_W'(OFS_ISR):  rd_val = isr;
        ADDR_W'(OFS_GIR):  rd_val = DW'({hmask, pending});
        default:           rd_val = '0;
      endcase
    end else if (page_q == PG_DATA) begin
      if (bus_addr == ADDR_W'(OFS_CNT_LO))      rd_val = rx_cnt[DW-1:0];
      else if (bus_addr == ADDR_W'(OFS_CNT_HI)) rd_val = {mirror, rx_cnt[CNT_W-1:DW]};
    end else if (page_q == PG_INTR) begin
      if (bus_addr == ADDR_W'(OFS_MASK))        rd_val = imr;
      else if (bus_addr == ADDR_W'(OFS_CFG))    rd_val = cfg_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  // R11
  sreset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    sreset |=> (page_q == '0 && isr == '0 && imr == '0 && cfg_q == '0 && !irq_en && !hmask));

  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/paged_host_regs_tb.sv
module paged_host_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [7:0]  mac_evt = '0;
  logic [3:0]  mac_stat = '0;
  logic [12:0] rx_cnt = '0;
  logic [7:0]  cmd_strobe;
  logic        host_irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  paged_host_regs dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .mac_evt(mac_evt), .mac_stat(mac_stat), .rx_cnt(rx_cnt),
    .cmd_strobe(cmd_strobe), .host_irq(host_irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk); mac_evt = e;
    @(negedge clk); mac_evt = '0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    rd(4'h1, v); chk("R11 reset page", v, 8'h00);
    rd(4'h6, v); chk("R11 reset status", v, 8'h00);
    rd(4'h7, v); chk("R11 reset gir", v, 8'h00);
    chk("R8 reset irq", {7'b0, host_irq}, 8'h00);
    chk("R12 reset strobe", cmd_strobe, 8'h00);
  endtask

  task automatic t_common();
    logic [7:0] v;
    do_reset();
    wr(4'h1, 8'h05);
    rd(4'h1, v); chk("R1 page readback", v, 8'h05);
    pulse(8'h02);
    rd(4'h6, v); chk("R1 status on page 5", v, 8'h02);
    mac_stat = 4'hA;
    rd(4'h0, v); chk("R1 status reg on page 5", v, 8'h0A);
  endtask

  task automatic t_status();
    logic [7:0] v;
    do_reset();
    mac_stat = 4'h5;
    rd(4'h0, v); chk("R3 stat 5", v, 8'h05);
    mac_stat = 4'hA;
    wr(4'h0, 8'h00);
    rd(4'h0, v); chk("R3 stat after cmd write", v, 8'h0A);
  endtask

  task automatic t_events();
    logic [7:0] v;
    do_reset();
    pulse(8'hFF);
    rd(4'h6, v); chk("R4 all events", v, 8'h77);
    pulse(8'h00);
    rd(4'h6, v); chk("R4 sticky", v, 8'h77);
  endtask

  task automatic t_w1c();
    logic [7:0] v;
    do_reset();
    pulse(8'h21);
    wr(4'h6, 8'h01);
    rd(4'h6, v); chk("R5 clear bit0", v, 8'h20);
    pulse(8'h01);
    @(negedge clk); bus_addr = 4'h6; bus_wdata = 8'h21; bus_wr = 1'b1; mac_evt = 8'h20;
    @(negedge clk); bus_wr = 1'b0; mac_evt = '0;
    rd(4'h6, v); chk("R5 event beats clear", v, 8'h20);
  endtask

  task automatic t_force();
    logic [7:0] v;
    do_reset();
    wr(4'h1, 8'h01);
    wr(4'hC, 8'h80);
    wr(4'h0, 8'h0C);
    rd(4'h6, v); chk("R6 forced bit", v, 8'h80);
    chk("R8 forced irq", {7'b0, host_irq}, 8'h01);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    do_reset();
    wr(4'h1, 8'h01);
    wr(4'hC, 8'h20);
    wr(4'h0, 8'h04);
    pulse(8'h20);
    rd(4'h7, v); chk("R9 pending", v, 8'h01);
    chk("R8 irq raised", {7'b0, host_irq}, 8'h01);
    wr(4'h7, 8'h02); @(negedge clk);
    chk("R8 host mask", {7'b0, host_irq}, 8'h00);
    rd(4'h7, v); chk("R9 mask readback", v, 8'h03);
    wr(4'h7, 8'h00); @(negedge clk);
    chk("R8 unmasked", {7'b0, host_irq}, 8'h01);
    wr(4'h0, 8'h00); @(negedge clk);
    chk("R7 enable off", {7'b0, host_irq}, 8'h00);
    rd(4'h7, v); chk("R9 pending w/o enable", v, 8'h01);
    wr(4'h6, 8'h20);
    pulse(8'h01);
    wr(4'h0, 8'h04); @(negedge clk);
    rd(4'h6, v); chk("R4 masked source latched", v, 8'h01);
    rd(4'h7, v); chk("R9 masked source", v, 8'h00);
    chk("R8 masked source", {7'b0, host_irq}, 8'h00);
  endtask

  task automatic t_strobe();
    do_reset();
    @(negedge clk); bus_addr = 4'h0; bus_wdata = 8'h75; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    chk("R12 strobe", cmd_strobe, 8'h71);
    @(negedge clk);
    chk("R12 strobe one cycle", cmd_strobe, 8'h00);
  endtask

  task automatic t_upper();
    logic [7:0] v;
    do_reset();
    wr(4'h1, 8'h01); wr(4'hC, 8'h5A); wr(4'hE, 8'h33);
    wr(4'h1, 8'h02); wr(4'hC, 8'hFF); wr(4'hE, 8'hFF);
    rd(4'hC, v); chk("R2 page2 reads zero", v, 8'h00);
    wr(4'h1, 8'h07);
    rd(4'hE, v); chk("R2 page7 reads zero", v, 8'h00);
    wr(4'h1, 8'h01);
    rd(4'hC, v); chk("R2 mask kept", v, 8'h5A);
    rd(4'hE, v); chk("R2 cfg kept", v, 8'h33);
  endtask

  task automatic t_count();
    logic [7:0] v;
    do_reset();
    rx_cnt = 13'h1ABC; mac_stat = 4'h5;
    rd(4'hE, v); chk("R2 count low", v, 8'hBC);
    rd(4'hF, v); chk("R10 mirror off", v, 8'h1A);
    wr(4'h1, 8'h01); wr(4'hE, 8'h80); wr(4'h1, 8'h00);
    rd(4'hF, v); chk("R10 mirror on", v, 8'hBA);
  endtask

  task automatic t_sreset();
    logic [7:0] v;
    do_reset();
    wr(4'h1, 8'h01); wr(4'hC, 8'hFF); wr(4'h7, 8'h02);
    pulse(8'h10);
    wr(4'h1, 8'h03);
    @(negedge clk); bus_addr = 4'h0; bus_wdata = 8'h0F; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    chk("R11 no strobe", cmd_strobe, 8'h00);
    rd(4'h1, v); chk("R11 page cleared", v, 8'h00);
    rd(4'h6, v); chk("R11 status cleared", v, 8'h00);
    rd(4'h7, v); chk("R11 gir cleared", v, 8'h00);
    wr(4'h1, 8'h01);
    rd(4'hC, v); chk("R11 mask cleared", v, 8'h00);
    chk("R11 irq low", {7'b0, host_irq}, 8'h00);
  endtask

  task automatic t_reads();
    logic [7:0] v;
    do_reset();
    pulse(8'h40);
    rd(4'h2, v); chk("R13 offset2 zero", v, 8'h00);
    rd(4'hA, v); chk("R13 page0 0x0A zero", v, 8'h00);
    rd(4'h6, v); rd(4'h6, v); chk("R13 read no clear", v, 8'h40);
    @(negedge clk); @(negedge clk);
    chk("R13 rdata holds", bus_rdata, 8'h40);
  endtask

  initial begin
    t_reset();
    t_common();
    t_status();
    t_events();
    t_w1c();
    t_force();
    t_irq();
    t_strobe();
    t_upper();
    t_count();
    t_sreset();
    t_reads();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule